// File: doc/BRIEF.md
# Byte-Lane Static RAM Sequencer

This block sits between an internal request bus and an external asynchronous static RAM of 128K words by 16 bits. Each word has two byte lanes, and each lane has its own active-low enable. One handshake on the request side becomes a timed sequence on the memory side. That sequence covers the chip select, write strobe and output strobe, the two lane enables, and the drive enable for the shared data pins. Each strobe window lasts a whole number of clock cycles. That number is computed from the clock period and the memory's access time, both given as parameters.

The request channel is valid/ready. A requester raises `req_valid` together with the address, write data, active-high lane mask and direction. It must hold them until a clock edge where `req_ready` is also high. That edge is the acceptance. For an access that touches at least one lane, `req_ready` falls on the next cycle and stays low until the memory is back in standby. While `req_ready` is low the block does not look at the request fields, so a requester that is held back only has to keep waiting. A request whose lane mask is all zero is accepted and finished in its own cycle, and the memory is never selected. Read results come out on `rd_data` with a one-cycle `rd_valid` pulse. This channel has no back-pressure, so the consumer must take the data in that cycle.

Between accesses the memory is deselected: chip select, both lane enables and both strobes are high, and the data pins are not driven. The external tristate buffer is built from `dq_out` and `dq_drive`, and the pin values come back on `dq_in`.

Top module: `sram_lane_ctrl`

## Requirements
- R1: `req_ready` is high exactly when the block is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. After an access with a non-zero mask is taken, `req_ready` is low on every cycle until the memory has returned to standby.
- R2: A write runs in three phases. First, one setup cycle with `mem_cs_n` low and `mem_we_n` high. Then `mem_we_n` is low for exactly HOLD cycles. Then one recovery cycle with `mem_we_n` high and `mem_cs_n` still low. Address, write data and lane enables keep the same value from the setup cycle through the recovery cycle, and `dq_out` carries the accepted write data.
- R3: Lane enables follow the mask for the whole access. Mask bit 0 drives `mem_lane_n[0]` low, which selects data bits 7:0. Mask bit 1 drives `mem_lane_n[1]` low, which selects bits 15:8. The two lanes act independently, and the chip is never selected unless at least one lane enable is low.
- R4: A read holds `mem_cs_n` and `mem_oe_n` low with `mem_we_n` high for exactly HOLD cycles. `dq_drive` is low for the whole read.
- R5: `dq_drive` is high only during the setup, strobe and recovery phases of a write. It is high only when `mem_oe_n` is high in that cycle and was also high in the cycle before, so there is one turnaround cycle between a read and a following write.
- R6: After reset, and after every access, the memory is in standby. Standby means `mem_cs_n`, `mem_we_n`, `mem_oe_n` and both lane enables are high and `dq_drive` is low.
- R7: Read data is sampled from `dq_in` on the last cycle of the read strobe. It appears on `rd_data` with `rd_valid` high for exactly one cycle, which is the first standby cycle. Lanes whose mask bit is 0 return zero.
- R8: A request with an all-zero lane mask completes in the cycle it is accepted. `mem_cs_n` never falls, `req_ready` stays high, no `rd_valid` is produced and the memory contents are untouched.
- R9: HOLD equals ACCESS_PS divided by CLK_PS, rounded up, with a minimum of 1. With the defaults (5000 ps clock, 55000 ps access) HOLD is 11.
- R10: `req_ready` is already high in the cycle `rd_valid` is pulsed, so the next request can be taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Active-high lane mask, bit 0 for low byte |
| rd_valid | output | 1 | One-cycle pulse marking read data |
| rd_data | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 17 | Address to the memory |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output strobe, active low |
| mem_lane_n | output | 2 | Lane enables, active low, bit 0 for bits 7:0 |
| dq_out | output | 16 | Data toward the pins |
| dq_drive | output | 1 | Drive enable for the pin tristate buffer |
| dq_in | input | 16 | Data read back from the pins |

## Verification
The completion cycle of a read is the one place where two functions meet. In that cycle the `rd_valid` pulse is delivered and a new request can be accepted. The bench provokes this by raising the next request on exactly that standby cycle, in both read-then-read and read-then-write orders. It judges the cycle by checking the returned lane-masked data and the high `req_ready` there. It then checks that `rd_valid` has dropped on the next cycle and that the new access's strobe sequence starts cleanly. In the read-then-write case this includes the turnaround rule for `dq_drive`.

// File: rtl/sram_lane_pkg.sv
`timescale 1ns/1ps
package sram_lane_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE     = 3'd0,
    SEQ_SETUP    = 3'd1,
    SEQ_WSTROBE  = 3'd2,
    SEQ_WRECOVER = 3'd3,
    SEQ_RSTROBE  = 3'd4
  } seq_state_e;

  // strobe window length in clock cycles, rounded up, never below one
  function automatic int unsigned hold_cycles(input int unsigned access_ps,
                                              input int unsigned clk_ps);
    int unsigned n;
    n = (access_ps + clk_ps - 1) / clk_ps;
    return (n == 0) ? 1 : n;
  endfunction

endpackage

// File: rtl/sram_seq_fsm.sv
`timescale 1ns/1ps
module sram_seq_fsm
  import sram_lane_pkg::*;
#(
  parameter int unsigned HOLD = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       start_write,
  output seq_state_e state_q,
  output seq_state_e state_nx,
  output logic       last_beat
);

  localparam int unsigned CNT_W = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD - 1);

  logic [CNT_W-1:0] cnt_q, cnt_nx;

  assign last_beat = (cnt_q == LAST);

  always_comb begin
    state_nx = state_q;
    cnt_nx   = cnt_q;
    case (state_q)
      SEQ_IDLE: begin
        if (start) begin
          state_nx = start_write ? SEQ_SETUP : SEQ_RSTROBE;
          cnt_nx   = '0;
        end
      end
      SEQ_SETUP: begin
        state_nx = SEQ_WSTROBE;
        cnt_nx   = '0;
      end
      SEQ_WSTROBE: begin
        if (last_beat) state_nx = SEQ_WRECOVER;
        else           cnt_nx   = cnt_q + 1'b1;
      end
      SEQ_WRECOVER: state_nx = SEQ_IDLE;
      SEQ_RSTROBE: begin
        if (last_beat) state_nx = SEQ_IDLE;
        else           cnt_nx   = cnt_q + 1'b1;
      end
      default: state_nx = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_nx;
      cnt_q   <= cnt_nx;
    end
  end

  // R9: the beat counter never runs past the strobe window
  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST)
    else $error("beat counter beyond window");

  // R2: a write strobe is always entered from the setup phase
  assert_wstrobe_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_SETUP) |=> (state_q == SEQ_WSTROBE))
    else $error("setup not followed by write strobe");

endmodule

// File: rtl/sram_req_latch.sv
`timescale 1ns/1ps
module sram_req_latch #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic [LANES-1:0]  in_mask,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q,
  output logic [LANES-1:0]  mask_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      mask_q <= '0;
    end else if (start) begin
      addr_q <= in_addr;
      data_q <= in_data;
      mask_q <= in_mask;
    end
  end

  // R2: captured fields never move while a new access is not being started
  assert_hold_fields_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(start) |-> ($stable(addr_q) && $stable(data_q) && $stable(mask_q)))
    else $error("latched request changed without a start");

endmodule

// File: rtl/sram_strobe_drv.sv
`timescale 1ns/1ps
module sram_strobe_drv
  import sram_lane_pkg::*;
#(
  parameter int unsigned LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  seq_state_e       state_nx,
  input  logic [LANES-1:0] mask_nx,
  output logic             cs_n,
  output logic             we_n,
  output logic             oe_n,
  output logic [LANES-1:0] lane_n,
  output logic             drive
);

  logic active_nx;
  logic drive_nx;

  assign active_nx = (state_nx != SEQ_IDLE);
  assign drive_nx  = (state_nx == SEQ_SETUP) || (state_nx == SEQ_WSTROBE) ||
                     (state_nx == SEQ_WRECOVER);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n   <= 1'b1;
      we_n   <= 1'b1;
      oe_n   <= 1'b1;
      lane_n <= '1;
      drive  <= 1'b0;
    end else begin
      cs_n  <= !active_nx;
      we_n  <= (state_nx != SEQ_WSTROBE);
      oe_n  <= (state_nx != SEQ_RSTROBE);
      drive <= drive_nx;
      for (int i = 0; i < LANES; i++) begin
        lane_n[i] <= !(active_nx && mask_nx[i]);
      end
    end
  end

  // R5: bus driven only after the output strobe has been high for a cycle
  assert_turnaround_R5: assert property (@(posedge clk) disable iff (!rst_n)
    drive |-> (oe_n && $past(oe_n)))
    else $error("bus driven without turnaround");

  // R4: no drive and no write strobe while the memory outputs data
  assert_no_drive_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (!drive && we_n && !cs_n))
    else $error("conflict during read");

  // R3: selecting the chip always enables at least one lane
  assert_lane_on_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> (lane_n != '1))
    else $error("chip selected with no lane");

  // R6: deselected means every lane and strobe inactive
  assert_standby_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> ((lane_n == '1) && we_n && oe_n && !drive))
    else $error("standby not clean");

endmodule

// File: rtl/sram_rd_capture.sv
`timescale 1ns/1ps
module sram_rd_capture #(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sample,
  input  logic [LANES-1:0]        mask,
  input  logic [LANE_W*LANES-1:0] pins,
  output logic                    rd_valid,
  output logic [LANE_W*LANES-1:0] rd_data
);

  localparam int unsigned DATA_W = LANE_W * LANES;

  logic [DATA_W-1:0] lane_val;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_val[g*LANE_W +: LANE_W] = mask[g] ? pins[g*LANE_W +: LANE_W] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= sample;
      if (sample) rd_data <= lane_val;
    end
  end

  // R7: the read-data strobe is a single-cycle pulse
  assert_rd_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid)
    else $error("rd_valid longer than one cycle");

endmodule

// File: rtl/sram_lane_ctrl.sv
`timescale 1ns/1ps
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int unsigned ADDR_W    = 17,
  parameter int unsigned LANE_W    = 8,
  parameter int unsigned LANES     = 2,
  parameter int unsigned CLK_PS    = 5000,
  parameter int unsigned ACCESS_PS = 55000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [LANE_W*LANES-1:0] req_wdata,
  input  logic [LANES-1:0]        req_mask,
  output logic                    rd_valid,
  output logic [LANE_W*LANES-1:0] rd_data,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic                    mem_cs_n,
  output logic                    mem_we_n,
  output logic                    mem_oe_n,
  output logic [LANES-1:0]        mem_lane_n,
  output logic [LANE_W*LANES-1:0] dq_out,
  output logic                    dq_drive,
  input  logic [LANE_W*LANES-1:0] dq_in
);

  localparam int unsigned DATA_W = LANE_W * LANES;
  localparam int unsigned HOLD   = hold_cycles(ACCESS_PS, CLK_PS);
  localparam int unsigned RUN_W  = $clog2(HOLD + 2);

  seq_state_e       st_q, st_nx;
  logic             last_beat;
  logic             accept, start, sample;
  logic [LANES-1:0] mask_q, mask_nx;

  assign req_ready = (st_q == SEQ_IDLE);
  assign accept    = req_valid && req_ready;
  assign start     = accept && (|req_mask);
  assign mask_nx   = start ? req_mask : mask_q;
  assign sample    = (st_q == SEQ_RSTROBE) && last_beat;

  sram_seq_fsm #(.HOLD(HOLD)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_write(req_write),
    .state_q    (st_q),
    .state_nx   (st_nx),
    .last_beat  (last_beat)
  );

  sram_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .in_addr(req_addr),
    .in_data(req_wdata),
    .in_mask(req_mask),
    .addr_q (mem_addr),
    .data_q (dq_out),
    .mask_q (mask_q)
  );

  sram_strobe_drv #(.LANES(LANES)) u_drv (
    .clk     (clk),
    .rst_n   (rst_n),
    .state_nx(st_nx),
    .mask_nx (mask_nx),
    .cs_n    (mem_cs_n),
    .we_n    (mem_we_n),
    .oe_n    (mem_oe_n),
    .lane_n  (mem_lane_n),
    .drive   (dq_drive)
  );

  sram_rd_capture #(.LANE_W(LANE_W), .LANES(LANES)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .sample  (sample),
    .mask    (mask_q),
    .pins    (dq_in),
    .rd_valid(rd_valid),
    .rd_data (rd_data)
  );

  // strobe run-length counters, used only by the window checks below
  logic [RUN_W-1:0] we_run, oe_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_run <= '0;
      oe_run <= '0;
    end else begin
      we_run <= mem_we_n ? '0 : we_run + 1'b1;
      oe_run <= mem_oe_n ? '0 : oe_run + 1'b1;
    end
  end

  // R2: write strobe width is exactly HOLD cycles
  assert_we_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_run == RUN_W'(HOLD)))
    else $error("write strobe width wrong");

  // R4: read strobe width is exactly HOLD cycles
  assert_oe_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (oe_run == RUN_W'(HOLD)))
    else $error("read strobe width wrong");

  // R2: write strobe falls only after a selected setup cycle
  assert_we_setup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> (!$past(mem_cs_n) && !mem_cs_n))
    else $error("no setup before write strobe");

  // R2: recovery cycle keeps the chip selected with stable address, data and lanes
  assert_we_recover_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (!mem_cs_n && $stable(mem_addr) && $stable(dq_out) &&
                          $stable(mem_lane_n)))
    else $error("recovery cycle disturbed");

  // R1: never ready while the memory is selected
  assert_busy_not_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> !req_ready)
    else $error("ready during access");

  // R8: an empty mask leaves the memory deselected
  assert_zero_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (req_mask == '0)) |=> (mem_cs_n && req_ready))
    else $error("empty-mask request selected the chip");

endmodule

// File: tb/test_sram_lane_ctrl.sv
`timescale 1ns/1ps
module test_sram_lane_ctrl;

  localparam int unsigned ADDR_W   = 17;
  localparam int unsigned LANE_W   = 8;
  localparam int unsigned LANES    = 2;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned CLK_PS   = 5000;
  localparam int unsigned ACC_PS   = 55000;
  localparam int unsigned HOLD_EXP = (ACC_PS + CLK_PS - 1) / CLK_PS;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid, req_ready, req_write;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata;
  logic [LANES-1:0]  req_mask;
  logic              rd_valid;
  logic [DATA_W-1:0] rd_data;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_cs_n, mem_we_n, mem_oe_n;
  logic [LANES-1:0]  mem_lane_n;
  logic [DATA_W-1:0] dq_out;
  logic              dq_drive;
  logic [DATA_W-1:0] dq_in;

  always #2.5 clk = ~clk;

  sram_lane_ctrl #(
    .ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES),
    .CLK_PS(CLK_PS), .ACCESS_PS(ACC_PS)
  ) i_sram_lane_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_lane_n(mem_lane_n),
    .dq_out(dq_out), .dq_drive(dq_drive), .dq_in(dq_in)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit prev_read = 1'b0;
  logic [ADDR_W-1:0] last_addr = '0;

  logic [DATA_W-1:0] sram_mem [256];
  logic [DATA_W-1:0] ref_mem  [256];

  // memory model: drives pins only while selected, reading, and lane enabled
  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      if (!mem_cs_n && !mem_oe_n && mem_we_n && !mem_lane_n[l])
        dq_in[l*LANE_W +: LANE_W] = sram_mem[mem_addr[7:0]][l*LANE_W +: LANE_W];
      else
        dq_in[l*LANE_W +: LANE_W] = 8'hC3;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !mem_cs_n && !mem_we_n) begin
      for (int l = 0; l < LANES; l++)
        if (!mem_lane_n[l])
          sram_mem[mem_addr[7:0]][l*LANE_W +: LANE_W] <= dq_out[l*LANE_W +: LANE_W];
    end
  end

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pack(input logic [ADDR_W-1:0] a, input logic r,
                                       input logic d, input logic o, input logic w,
                                       input logic c, input logic [1:0] ln);
    return {8'h00, a, r, d, o, w, c, ln};
  endfunction

  function automatic logic [31:0] obs();
    return pack(mem_addr, req_ready, dq_drive, mem_oe_n, mem_we_n, mem_cs_n, mem_lane_n);
  endfunction

  function automatic logic [DATA_W-1:0] exp_read(input logic [ADDR_W-1:0] a,
                                                 input logic [1:0] m);
    logic [DATA_W-1:0] v;
    for (int l = 0; l < LANES; l++)
      v[l*LANE_W +: LANE_W] = m[l] ? ref_mem[a[7:0]][l*LANE_W +: LANE_W] : 8'h00;
    return v;
  endfunction

  task automatic idle(input int n);
    logic [31:0] e;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (prev_read) begin
        chk(rd_valid == 1'b0, "R7 pulse ends", 32'(rd_valid), 32'd0);
        prev_read = 1'b0;
      end
      e = pack(last_addr, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'b11);
      chk(obs() == e, "R6 idle standby", obs(), e);
    end
  endtask

  // called on a negedge; returns on the negedge of the first standby cycle
  task automatic access(input bit wr, input logic [ADDR_W-1:0] a,
                        input logic [DATA_W-1:0] d, input logic [1:0] m);
    logic [31:0] e;
    logic [DATA_W-1:0] er;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    @(posedge clk);
    while (!req_ready) @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    req_addr  = ADDR_W'($urandom);
    req_wdata = DATA_W'($urandom);
    req_mask  = 2'($urandom);
    if (prev_read) begin
      chk(rd_valid == 1'b0, "R7 pulse ends", 32'(rd_valid), 32'd0);
      prev_read = 1'b0;
    end
    if (m == 2'b00) begin
      e = pack(last_addr, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'b11);
      chk(obs() == e && !rd_valid, "R8 empty mask", obs(), e);
      return;
    end
    last_addr = a;
    if (wr) begin
      for (int l = 0; l < LANES; l++)
        if (m[l]) ref_mem[a[7:0]][l*LANE_W +: LANE_W] = d[l*LANE_W +: LANE_W];
      e = pack(a, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, ~m);
      chk(obs() == e, "R2 R3 R5 write setup", obs(), e);
      chk(dq_out == d, "R2 write data", 32'(dq_out), 32'(d));
      for (int i = 0; i < HOLD_EXP; i++) begin
        @(negedge clk);
        e = pack(a, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, ~m);
        chk(obs() == e, "R2 R3 R9 write strobe", obs(), e);
      end
      @(negedge clk);
      e = pack(a, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, ~m);
      chk(obs() == e && dq_out == d, "R2 write recovery", obs(), e);
      @(negedge clk);
      e = pack(a, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'b11);
      chk(obs() == e && !rd_valid, "R1 R6 standby after write", obs(), e);
    end else begin
      er = exp_read(a, m);
      for (int i = 0; i < HOLD_EXP; i++) begin
        if (i > 0) @(negedge clk);
        e = pack(a, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, ~m);
        chk(obs() == e && !rd_valid, "R1 R3 R4 R9 read strobe", obs(), e);
      end
      @(negedge clk);
      e = pack(a, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'b11);
      chk(obs() == e, "R6 R10 standby and ready after read", obs(), e);
      chk(rd_valid == 1'b1, "R7 read valid", 32'(rd_valid), 32'd1);
      chk(rd_data == er, "R7 read data", 32'(rd_data), 32'(er));
      prev_read = 1'b1;
    end
  endtask

  initial begin
    logic [31:0] e;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 256; i++) begin
      sram_mem[i] = '0;
      ref_mem[i]  = '0;
    end
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; req_mask = '0;
    repeat (4) @(negedge clk);
    e = pack('0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 2'b11);
    chk(obs() == e && !rd_valid, "R6 reset state", obs(), e);
    rst_n = 1'b1;
    idle(2);

    // directed: top address, full word
    access(1'b1, 17'h1FFFF, 16'hBEEF, 2'b11);
    access(1'b0, 17'h1FFFF, 16'h0000, 2'b11);
    // independent lanes (R3)
    access(1'b1, 17'h00010, 16'h1234, 2'b01);
    access(1'b1, 17'h00010, 16'h5678, 2'b10);
    access(1'b0, 17'h00010, 16'h0000, 2'b11);
    access(1'b0, 17'h00010, 16'h0000, 2'b01);
    access(1'b0, 17'h00010, 16'h0000, 2'b10);
    // empty masks must leave memory untouched (R8)
    access(1'b1, 17'h00010, 16'hFFFF, 2'b00);
    access(1'b0, 17'h00010, 16'h0000, 2'b00);
    access(1'b0, 17'h00010, 16'h0000, 2'b11);
    // read immediately followed by write: turnaround (R5, R10)
    access(1'b1, 17'h0A5A5, 16'hC0DE, 2'b11);
    access(1'b0, 17'h0A5A5, 16'h0000, 2'b11);
    access(1'b0, 17'h0A5A5, 16'h0000, 2'b10);
    idle(3);

    // constrained random mix
    for (int n = 0; n < 300; n++) begin
      logic [ADDR_W-1:0] a;
      a = {9'($urandom), 8'($urandom % 16)};
      if (($urandom % 8) == 0) idle(1 + ($urandom % 3));
      access(1'($urandom), a, 16'($urandom), 2'($urandom));
    end
    idle(2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1: actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule